// File: doc/BRIEF.md
# Dual-Channel Motor-Signal Duty Decoder

This block recovers a small numeric code from the duty cycle of two bidirectional motor-drive signals. Each channel has a forward line and a reverse line, and both are active low. On every tick the block samples all four lines. Across a fixed measurement window it counts how many samples found each line low. At the end of the window each count is reduced to a coarse level. The two levels of a channel are then folded into a single channel code. The forward level is the code when it is nonzero. When only the reverse line was active, the code is the reverse level plus an offset.

A code pair is only handed on once it has been seen unchanged over consecutive windows. When a window's code for channel A differs from the held copy, only that copy is refreshed. Channel B is examined only if channel A already matched. The pair is offered when both codes match their held copies and neither is zero.

The offered pair stays on the output bus, with its valid flag high, until downstream logic pulses a consume strobe. While a pair is waiting, window results are thrown away. The tick is a one-cycle enable supplied from outside.

Top module: `duty_pair_decoder`

## Requirements
- R1: After reset `pair_valid` is 0 and `pair_code` is 0. Both held codes are 0 and a fresh window of `WIN_TICKS` (default 32) ticks begins.
- R2: A line is sampled only in cycles where `tick` is 1, and a sample counts when the line is 0. Levels on the lines in other cycles have no effect on any result.
- R3: At the end of a window each line's low count n becomes the level (n + 2) >> 2. With the default window this level runs from 0 to 8.
- R4: A channel code equals the forward level when that level is nonzero, or when the reverse level is zero. If the forward level is 0 and the reverse level is nonzero, the code is the reverse level + 8, giving codes 9 to 16.
- R5: A window is exactly `WIN_TICKS` ticks long. The tick that ends a window is counted in it. All four counts restart from zero for the next window.
- R6: At a window end with no pair pending, the steps are tried in order. If the channel A code differs from its held copy, only that copy takes the new value. Otherwise, if the channel B code differs from its held copy, only that copy takes the new value. Otherwise a pair is offered. A new pair therefore needs at least two windows with identical codes.
- R7: A pair is never offered while either held code is 0.
- R8: While `pair_valid` is 1, window results are discarded. The held codes, and so `pair_code`, stay unchanged.
- R9: A one-cycle `pair_take` while `pair_valid` is 1 clears `pair_valid` on the next clock edge. `pair_code` reads 0 whenever `pair_valid` is 0. The bus layout is: bits [4:0] hold the channel A code and bits [9:5] hold the channel B code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle sample enable |
| lines_n | input | 4 | Active-low drive lines: bit 0 A forward, bit 1 A reverse, bit 2 B forward, bit 3 B reverse |
| pair_take | input | 1 | One-cycle consume strobe from downstream |
| pair_valid | output | 1 | A stable code pair is offered |
| pair_code | output | 10 | {channel B code, channel A code} while valid, else 0 |

## Verification
The hardest situation to reach from the ports is a window whose result is dropped because a pair is still pending, followed by proof that the held copies kept their old values. The bench reaches it in three steps. It lets a pair become pending, runs two windows with completely different duty patterns without consuming the pair, and then consumes it. One further window with the original duties must then deliver at once. That immediate delivery is only possible if the held copies were left untouched. Full sweeps of forward and reverse low counts from 0 to 32 cover every quantization step and both sides of the reverse-offset rule. One window holds each line at the opposite level between ticks, to show that only tick cycles are sampled.

// File: rtl/dpd_pkg.sv
// Package: shared line indices for the duty decoder.
// Assumes the four drive lines are packed into one vector in this order.
package dpd_pkg;
    localparam int LINE_A_FWD = 0;
    localparam int LINE_A_REV = 1;
    localparam int LINE_B_FWD = 2;
    localparam int LINE_B_REV = 3;
    localparam int NUM_LINES  = 4;
endpackage

// File: rtl/dpd_window_timer.sv
// Module: counts ticks in a measurement window and flags the final tick.
// Assumes tick is a single-cycle enable; the window length is WIN_TICKS >= 2.
module dpd_window_timer #(
    parameter int WIN_TICKS = 32,
    localparam int WT_W = $clog2(WIN_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic win_end
);
    logic [WT_W-1:0] left_q;

    assign win_end = tick && (left_q == WT_W'(1));

    // Count ticks down and reload once a window has finished.
    always_ff @(posedge clk) begin
        if (!rst_n)       left_q <= WT_W'(WIN_TICKS);
        else if (win_end) left_q <= WT_W'(WIN_TICKS);
        else if (tick)    left_q <= left_q - WT_W'(1);
    end

    p_left_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (left_q >= WT_W'(1)) && (left_q <= WT_W'(WIN_TICKS)));
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (left_q == WT_W'(WIN_TICKS)));
endmodule

// File: rtl/dpd_low_counter.sv
// Module: counts low samples of one active-low line during a window.
// Assumes win_end coincides with the window's final tick; that tick's sample is included in total.
module dpd_low_counter #(
    parameter int WIN_TICKS = 32,
    localparam int CNT_W = $clog2(WIN_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             line_n,
    input  logic             win_end,
    output logic [CNT_W-1:0] total
);
    logic [CNT_W-1:0] cnt_q;

    assign total = cnt_q + CNT_W'(tick && !line_n);

    // Accumulate low samples; restart at each window boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (win_end) cnt_q <= '0;
        else if (tick)    cnt_q <= total;
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(WIN_TICKS));
endmodule

// File: rtl/dpd_channel_coder.sv
// Module: quantizes a channel's forward and reverse counts and folds direction into one code.
// Assumes counts are final window totals (combinational path, no state).
module dpd_channel_coder #(
    parameter int CNT_W   = 6,
    parameter int QSHIFT  = 2,
    parameter int REV_OFF = 8,
    parameter int CODE_W  = 5,
    localparam int QW  = CNT_W + 1,
    localparam int RND = 1 << (QSHIFT - 1)
) (
    input  logic [CNT_W-1:0]  fwd_cnt,
    input  logic [CNT_W-1:0]  rev_cnt,
    output logic [CODE_W-1:0] code
);
    logic [QW-1:0] fwd_lvl;
    logic [QW-1:0] rev_lvl;

    // Rounded division of each count by 2^QSHIFT, then direction folding.
    always_comb begin
        fwd_lvl = ({1'b0, fwd_cnt} + QW'(RND)) >> QSHIFT;
        rev_lvl = ({1'b0, rev_cnt} + QW'(RND)) >> QSHIFT;
        if (fwd_lvl == '0 && rev_lvl != '0)
            code = CODE_W'(rev_lvl) + CODE_W'(REV_OFF);
        else
            code = CODE_W'(fwd_lvl);
    end
endmodule

// File: rtl/dpd_pair_stabilizer.sv
// Module: keeps held copies of both channel codes and offers a pair once both repeat.
// Assumes win_end is a one-cycle pulse and take is a one-cycle strobe.
module dpd_pair_stabilizer #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_end,
    input  logic [CODE_W-1:0] code_a,
    input  logic [CODE_W-1:0] code_b,
    input  logic              take,
    output logic              full,
    output logic [CODE_W-1:0] held_a,
    output logic [CODE_W-1:0] held_b
);
    // Stability check at window end, consume handling, discard while full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            held_a <= '0;
            held_b <= '0;
        end else begin
            if (take && full) full <= 1'b0;
            if (win_end && !full) begin
                if (code_a != held_a)                  held_a <= code_a;
                else if (code_b != held_b)             held_b <= code_b;
                else if (held_a != '0 && held_b != '0) full   <= 1'b1;
            end
        end
    end

    p_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (held_a != '0) && (held_b != '0));
    p_rise_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(win_end));
    p_one_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (held_a != $past(held_a)) |-> (held_b == $past(held_b)));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take) |=> full && $stable(held_a) && $stable(held_b));
    p_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && take) |=> !full);
endmodule

// File: rtl/duty_pair_decoder.sv
// Module: top of the dual-channel motor-signal duty decoder.
// Assumes tick is a one-cycle enable and lines_n follows the dpd_pkg line order.
module duty_pair_decoder #(
    parameter int WIN_TICKS = 32,
    parameter int QSHIFT    = 2,
    parameter int REV_OFF   = 8,
    localparam int CNT_W    = $clog2(WIN_TICKS + 1),
    localparam int LVL_MAX  = (WIN_TICKS + (1 << (QSHIFT - 1))) >> QSHIFT,
    localparam int CODE_W   = $clog2(LVL_MAX + REV_OFF + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic [3:0]              lines_n,
    input  logic                    pair_take,
    output logic                    pair_valid,
    output logic [2*CODE_W-1:0]     pair_code
);
    import dpd_pkg::*;

    logic             win_end;
    logic [CNT_W-1:0] totals [NUM_LINES];
    logic [CODE_W-1:0] codes [2];
    logic [CODE_W-1:0] held_a;
    logic [CODE_W-1:0] held_b;
    logic              full;

    dpd_window_timer #(.WIN_TICKS(WIN_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .win_end(win_end)
    );

    for (genvar li = 0; li < NUM_LINES; li++) begin : g_line
        dpd_low_counter #(.WIN_TICKS(WIN_TICKS)) u_cnt (
            .clk(clk), .rst_n(rst_n), .tick(tick), .line_n(lines_n[li]),
            .win_end(win_end), .total(totals[li])
        );
    end

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        dpd_channel_coder #(
            .CNT_W(CNT_W), .QSHIFT(QSHIFT), .REV_OFF(REV_OFF), .CODE_W(CODE_W)
        ) u_coder (
            .fwd_cnt(totals[2*ch + LINE_A_FWD]),
            .rev_cnt(totals[2*ch + LINE_A_REV]),
            .code(codes[ch])
        );
    end

    dpd_pair_stabilizer #(.CODE_W(CODE_W)) u_stab (
        .clk(clk), .rst_n(rst_n), .win_end(win_end),
        .code_a(codes[0]), .code_b(codes[1]), .take(pair_take),
        .full(full), .held_a(held_a), .held_b(held_b)
    );

    assign pair_valid = full;
    assign pair_code  = full ? {held_b, held_a} : '0;

    p_idle_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |-> (pair_code == '0));
endmodule

// File: tb/duty_pair_decoder_bench.sv
`timescale 1ns/1ps
module duty_pair_decoder_bench;
    localparam int WIN = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] lines_n = 4'hF;
    logic       pair_take = 1'b0;
    logic       pair_valid;
    logic [9:0] pair_code;

    int checks = 0;
    int fails  = 0;
    int m_ha = 0, m_hb = 0;
    bit m_full = 1'b0;

    always #2 clk = ~clk;

    duty_pair_decoder u_duty_pair_decoder (
        .clk(clk), .rst_n(rst_n), .tick(tick), .lines_n(lines_n),
        .pair_take(pair_take), .pair_valid(pair_valid), .pair_code(pair_code)
    );

    function automatic int lvl(input int n);
        return (n + 2) / 4;
    endfunction

    function automatic int chan_code(input int f, input int r);
        if (lvl(f) == 0 && lvl(r) != 0) return lvl(r) + 8;
        return lvl(f);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_out(input string req);
        int exp_code;
        exp_code = m_full ? (m_hb * 32 + m_ha) : 0;
        check(pair_valid == m_full, req, int'(pair_valid), int'(m_full));
        check(int'(pair_code) == exp_code, req, int'(pair_code), exp_code);
    endtask

    // One window: each line low at its first L tick samples; glitch inverts lines between ticks.
    task automatic window(input int fa, input int ra, input int fb, input int rb,
                          input bit glitch, input string req);
        for (int t = 0; t < WIN; t++) begin
            @(negedge clk);
            lines_n[0] = !(t < fa);
            lines_n[1] = !(t < ra);
            lines_n[2] = !(t < fb);
            lines_n[3] = !(t < rb);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            if (glitch) lines_n = ~lines_n;
            repeat (2) @(negedge clk);
        end
        lines_n = 4'hF;
        if (!m_full) begin
            if (chan_code(fa, ra) != m_ha)      m_ha = chan_code(fa, ra);
            else if (chan_code(fb, rb) != m_hb) m_hb = chan_code(fb, rb);
            else if (m_ha != 0 && m_hb != 0)    m_full = 1'b1;
        end
        check_out(req);
    endtask

    task automatic take_pair(input string req);
        @(negedge clk);
        pair_take = 1'b1;
        @(negedge clk);
        pair_take = 1'b0;
        m_full = 1'b0;
        check_out(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_out("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 after release");

        // R6: A settles, then B, then pair offered in the third window
        window(8, 0, 12, 0, 1'b0, "R6 window1");
        check(pair_valid == 1'b0, "R6 no early pair", int'(pair_valid), 0);
        window(8, 0, 12, 0, 1'b0, "R6 window2");
        window(8, 0, 12, 0, 1'b0, "R6 window3");
        check(pair_valid == 1'b1, "R6 delivered", int'(pair_valid), 1);
        take_pair("R9 consume");

        // R3 / R5: forward low-count sweep on A, B held on reverse
        for (int n = 0; n <= WIN; n++) begin
            for (int w = 0; w < 3; w++) begin
                window(n, 0, 0, 20, 1'b0, "R3 fwd sweep");
                if (m_full) take_pair("R9 sweep take");
            end
        end

        // R4: reverse sweep on A with forward silent
        for (int n = 0; n <= WIN; n++) begin
            for (int w = 0; w < 3; w++) begin
                window(0, n, 4, 0, 1'b0, "R4 rev sweep");
                if (m_full) take_pair("R9 sweep take");
            end
        end

        // R4: both lines active, forward level wins
        for (int w = 0; w < 3; w++) window(12, 20, 30, 30, 1'b0, "R4 both active");
        if (m_full) take_pair("R9 take");

        // R7: zero code on A never offered
        for (int w = 0; w < 3; w++) window(1, 1, 8, 0, 1'b0, "R7 zero code");
        check(pair_valid == 1'b0, "R7 stays idle", int'(pair_valid), 0);

        // R8: discard while pending, then held copies prove untouched
        for (int w = 0; w < 3; w++) window(16, 0, 16, 0, 1'b0, "R8 setup");
        window(0, 24, 0, 24, 1'b0, "R8 discard1");
        window(2, 0, 31, 0, 1'b0, "R8 discard2");
        take_pair("R9 take after discard");
        window(16, 0, 16, 0, 1'b0, "R8 immediate redelivery");
        check(pair_valid == 1'b1, "R8 redelivered", int'(pair_valid), 1);
        take_pair("R9 take");

        // R2: lines toggled between ticks must not count
        window(16, 0, 16, 0, 1'b1, "R2 between-tick levels ignored");
        check(pair_valid == 1'b1, "R2 delivered", int'(pair_valid), 1);
        take_pair("R9 final take");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule